// File: doc/BRIEF.md
# Pixel Port Formatter and Palette Selector

This block sits between a frame buffer's pixel bus and a colour lookup table. Each time the load strobe is asserted it takes in two 24-bit pixel words (port A and port B), a blank bit, a sync bit and a two-bit palette-select code for each pixel. In 1:1 mode only port A is used and a new load arrives every clock. In 2:1 mode a load arrives every second clock, and the two captured pixels go out one per clock, A first and then B.

Every outgoing pixel becomes three table addresses, one for the red, green and blue channels. How the address bits are taken from the input depends on the colour format code. The formats are direct 24-bit colour, three 8-bit indexed formats (one input channel indexes all three table channels), and two packed 15-bit formats that reach only table entries 0 to 31. A per-pixel compare between the pixel's palette-select code and a programmed code enables or disables the output. The block also passes on blank, a width flag for the table (10 or 8 bits per channel), a gated sync-on-green request and a separate gated sync output. All of these leave through one output register, so they stay aligned with the addresses.

Top module: `pxfmt_top`

## Requirements
- R1: A pixel whose load strobe is high at clock edge N shows on the outputs after edge N+1. If no further strobe comes in 1:1 mode, that pixel stays on the outputs.
- R2: In 2:1 mode (`mux2_i`=1), port A's pixel shows after edge N+1 and port B's pixel after edge N+2. Pixel words are packed red[23:16], green[15:8], blue[7:0].
- R3: When `fmt_cfg_i[3:1]`=3'b111, the red, green and blue addresses are the pixel's red, green and blue bytes unchanged.
- R4: When `fmt_cfg_i[3:2]` is 2'b00, 2'b01 or 2'b10, the red, green or blue byte respectively drives all three addresses. `fmt_cfg_i[1:0]` is ignored.
- R5: When `fmt_cfg_i`=4'b1100, the addresses are red[7:3], green[7:3] and blue[7:3], each zero-extended to 8 bits.
- R6: When `fmt_cfg_i`=4'b1101, the addresses are red[7:3], {red[2:0],green[6:5]} and green[4:0], each zero-extended. Blue and green[7] have no effect.
- R7: `wide_o` presents `wide_i` with the same one-cycle output latency. 1 means 10 bits per channel and 0 means 8 bits.
- R8: Each pixel's own 2-bit select code is compared with `pal_code_i`. On a mismatch, `en_o` is 0 and all three addresses are 0 whatever the pixel data is. On a match, `en_o` is 1.
- R9: `sog_o` is the captured sync when `sog_en_i`=1 and is 0 otherwise.
- R10: `sync_o` is the captured sync when `sync_out_en_i`=1 and is 0 otherwise. `blank_o` is the captured blank. Both have the same latency as the addresses and apply to both pixels of a 2:1 load.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe; captures ports on this edge |
| mux2_i | input | 1 | 1 = 2:1 serialisation, 0 = 1:1 |
| fmt_cfg_i | input | 4 | Colour format code |
| wide_i | input | 1 | Table width: 1 = 10-bit, 0 = 8-bit |
| pal_code_i | input | 2 | Programmed palette-select code |
| sog_en_i | input | 1 | Allow sync on green |
| sync_out_en_i | input | 1 | Allow separate sync output |
| pix_a_i | input | 24 | Port A pixel |
| pix_b_i | input | 24 | Port B pixel |
| psel_a_i | input | 2 | Port A select code |
| psel_b_i | input | 2 | Port B select code |
| sync_i | input | 1 | Sync for the load |
| blank_i | input | 1 | Blank for the load |
| addr_r_o | output | 8 | Red table address |
| addr_g_o | output | 8 | Green table address |
| addr_b_o | output | 8 | Blue table address |
| wide_o | output | 1 | Width flag, aligned |
| blank_o | output | 1 | Blank, aligned |
| sog_o | output | 1 | Sync-on-green request |
| sync_o | output | 1 | Separate sync output |
| en_o | output | 1 | Output enable (select match) |

## Verification
The pixel words are chosen so that their red, green and blue bytes differ in every bit field each mapping uses. A wrong byte choice or a shifted 15-bit slice therefore gives a different address. Back-to-back 1:1 loads, a load followed by idle clocks, and 2:1 loads with distinct A and B words separate capture timing from serialisation order. In 2:1 loads where only one of the two select codes matches, a select code taken from the wrong pixel shows up as a failure. Sync and blank are toggled under each enable setting to tell gating apart from latency.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;
  localparam int CH_W    = 8;
  localparam int N_CH    = 3;
  localparam int PIX_W   = CH_W * N_CH;
  localparam int IDX15_W = 5;
  localparam int CFG_W   = 4;

  typedef enum logic [2:0] {
    FMT_DIRECT   = 3'd0,
    FMT_IDX_R    = 3'd1,
    FMT_IDX_G    = 3'd2,
    FMT_IDX_B    = 3'd3,
    FMT_PACK_RGB = 3'd4,
    FMT_PACK_RG  = 3'd5
  } fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // cfg[0] = packing variant, cfg[1] = direct qualifier, cfg[3:2] = channel code
  function automatic fmt_e decode_fmt(input logic [CFG_W-1:0] cfg);
    fmt_e f;
    unique case (cfg[3:2])
      2'b00:   f = FMT_IDX_R;
      2'b01:   f = FMT_IDX_G;
      2'b10:   f = FMT_IDX_B;
      default: begin
        if (cfg[1])      f = FMT_DIRECT;
        else if (cfg[0]) f = FMT_PACK_RG;
        else             f = FMT_PACK_RGB;
      end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/pxfmt_capture.sv
module pxfmt_capture
  import pxfmt_pkg::*;
#(
  parameter int PS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             mux2_i,
  input  logic [PIX_W-1:0] pix_a_i,
  input  logic [PIX_W-1:0] pix_b_i,
  input  logic [PS_W-1:0]  ps_a_i,
  input  logic [PS_W-1:0]  ps_b_i,
  input  logic             sync_i,
  input  logic             blank_i,
  output rgb_t             cur_pix_o,
  output logic [PS_W-1:0]  cur_ps_o,
  output logic             cur_sync_o,
  output logic             cur_blank_o
);
  rgb_t            a_q, a_d, b_q, b_d;
  logic [PS_W-1:0] psa_q, psa_d, psb_q, psb_d;
  logic            sync_q, sync_d, blank_q, blank_d;
  logic            selb_q, selb_d;

  always_comb begin
    a_d     = a_q;
    b_d     = b_q;
    psa_d   = psa_q;
    psb_d   = psb_q;
    sync_d  = sync_q;
    blank_d = blank_q;
    selb_d  = mux2_i ? 1'b1 : 1'b0;
    if (load_i) begin
      a_d     = rgb_t'(pix_a_i);
      b_d     = rgb_t'(pix_b_i);
      psa_d   = ps_a_i;
      psb_d   = ps_b_i;
      sync_d  = sync_i;
      blank_d = blank_i;
      selb_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      psa_q   <= '0;
      psb_q   <= '0;
      sync_q  <= 1'b0;
      blank_q <= 1'b0;
      selb_q  <= 1'b0;
    end else begin
      a_q     <= a_d;
      b_q     <= b_d;
      psa_q   <= psa_d;
      psb_q   <= psb_d;
      sync_q  <= sync_d;
      blank_q <= blank_d;
      selb_q  <= selb_d;
    end
  end

  assign cur_pix_o   = selb_q ? b_q : a_q;
  assign cur_ps_o    = selb_q ? psb_q : psa_q;
  assign cur_sync_o  = sync_q;
  assign cur_blank_o = blank_q;
endmodule

// File: rtl/pxfmt_map.sv
module pxfmt_map
  import pxfmt_pkg::*;
(
  input  fmt_e fmt_i,
  input  rgb_t pix_i,
  output rgb_t addr_o
);
  localparam int PAD_W = CH_W - IDX15_W;

  logic [N_CH-1:0][CH_W-1:0] chans;
  logic [N_CH-1:0][CH_W-1:0] pack_rgb;
  rgb_t                      pack_rg;

  assign chans = pix_i;

  // top five bits of every channel, each landing in its own channel
  for (genvar i = 0; i < N_CH; i++) begin : g_pack
    assign pack_rgb[i] = {{PAD_W{1'b0}}, chans[i][CH_W-1 -: IDX15_W]};
  end

  // fifteen bits from red[7:0] and green[6:0], split five per channel
  logic [3*IDX15_W-1:0] rg_bits;
  assign rg_bits   = {pix_i.r, pix_i.g[3*IDX15_W-CH_W-1:0]};
  assign pack_rg.r = {{PAD_W{1'b0}}, rg_bits[3*IDX15_W-1 -: IDX15_W]};
  assign pack_rg.g = {{PAD_W{1'b0}}, rg_bits[2*IDX15_W-1 -: IDX15_W]};
  assign pack_rg.b = {{PAD_W{1'b0}}, rg_bits[IDX15_W-1:0]};

  always_comb begin
    unique case (fmt_i)
      FMT_DIRECT:   addr_o = pix_i;
      FMT_IDX_R:    addr_o = '{r: pix_i.r, g: pix_i.r, b: pix_i.r};
      FMT_IDX_G:    addr_o = '{r: pix_i.g, g: pix_i.g, b: pix_i.g};
      FMT_IDX_B:    addr_o = '{r: pix_i.b, g: pix_i.b, b: pix_i.b};
      FMT_PACK_RGB: addr_o = rgb_t'(pack_rgb);
      FMT_PACK_RG:  addr_o = pack_rg;
      default:      addr_o = '0;
    endcase
  end
endmodule

// File: rtl/pxfmt_out.sv
module pxfmt_out
  import pxfmt_pkg::*;
#(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rgb_t            addr_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic [PS_W-1:0] pal_code_i,
  input  logic            sync_i,
  input  logic            blank_i,
  input  logic            wide_i,
  input  logic            sog_en_i,
  input  logic            sync_out_en_i,
  output rgb_t            addr_o,
  output logic            en_o,
  output logic            wide_o,
  output logic            blank_o,
  output logic            sog_o,
  output logic            sync_o
);
  rgb_t addr_d;
  logic en_d, sog_d, syo_d;

  always_comb begin
    en_d   = (ps_i == pal_code_i);
    addr_d = en_d ? addr_i : '0;
    sog_d  = sync_i & sog_en_i;
    syo_d  = sync_i & sync_out_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      en_o    <= 1'b0;
      wide_o  <= 1'b0;
      blank_o <= 1'b0;
      sog_o   <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      en_o    <= en_d;
      wide_o  <= wide_i;
      blank_o <= blank_i;
      sog_o   <= sog_d;
      sync_o  <= syo_d;
    end
  end
endmodule

// File: rtl/pxfmt_top.sv
module pxfmt_top
  import pxfmt_pkg::*;
#(
  parameter int PS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             mux2_i,
  input  logic [CFG_W-1:0] fmt_cfg_i,
  input  logic             wide_i,
  input  logic [PS_W-1:0]  pal_code_i,
  input  logic             sog_en_i,
  input  logic             sync_out_en_i,
  input  logic [PIX_W-1:0] pix_a_i,
  input  logic [PIX_W-1:0] pix_b_i,
  input  logic [PS_W-1:0]  psel_a_i,
  input  logic [PS_W-1:0]  psel_b_i,
  input  logic             sync_i,
  input  logic             blank_i,
  output logic [CH_W-1:0]  addr_r_o,
  output logic [CH_W-1:0]  addr_g_o,
  output logic [CH_W-1:0]  addr_b_o,
  output logic             wide_o,
  output logic             blank_o,
  output logic             sog_o,
  output logic             sync_o,
  output logic             en_o
);
  rgb_t            cur_pix, mapped, addr_q;
  logic [PS_W-1:0] cur_ps;
  logic            cur_sync, cur_blank;
  fmt_e            fmt;

  assign fmt = decode_fmt(fmt_cfg_i);

  pxfmt_capture #(.PS_W(PS_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .mux2_i     (mux2_i),
    .pix_a_i    (pix_a_i),
    .pix_b_i    (pix_b_i),
    .ps_a_i     (psel_a_i),
    .ps_b_i     (psel_b_i),
    .sync_i     (sync_i),
    .blank_i    (blank_i),
    .cur_pix_o  (cur_pix),
    .cur_ps_o   (cur_ps),
    .cur_sync_o (cur_sync),
    .cur_blank_o(cur_blank)
  );

  pxfmt_map u_map (
    .fmt_i (fmt),
    .pix_i (cur_pix),
    .addr_o(mapped)
  );

  pxfmt_out #(.PS_W(PS_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (mapped),
    .ps_i         (cur_ps),
    .pal_code_i   (pal_code_i),
    .sync_i       (cur_sync),
    .blank_i      (cur_blank),
    .wide_i       (wide_i),
    .sog_en_i     (sog_en_i),
    .sync_out_en_i(sync_out_en_i),
    .addr_o       (addr_q),
    .en_o         (en_o),
    .wide_o       (wide_o),
    .blank_o      (blank_o),
    .sog_o        (sog_o),
    .sync_o       (sync_o)
  );

  assign addr_r_o = addr_q.r;
  assign addr_g_o = addr_q.g;
  assign addr_b_o = addr_q.b;
endmodule

// File: rtl/pxfmt_chk.sv
module pxfmt_chk
  import pxfmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] fmt_cfg_i,
  input logic             wide_i,
  input logic             sog_en_i,
  input logic             sync_out_en_i,
  input logic [CH_W-1:0]  addr_r_o,
  input logic [CH_W-1:0]  addr_g_o,
  input logic [CH_W-1:0]  addr_b_o,
  input logic             wide_o,
  input logic             sog_o,
  input logic             sync_o,
  input logic             en_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  p_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (wide_o == $past(wide_i)));

  p_sog_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(sog_en_i)) |-> !sog_o);

  p_syo_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(sync_out_en_i)) |-> !sync_o);

  p_off_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (addr_r_o == '0 && addr_g_o == '0 && addr_b_o == '0));

  p_idx_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(fmt_cfg_i[3:2] != 2'b11))
      |-> (addr_r_o == addr_g_o && addr_g_o == addr_b_o));

  p_pack_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(fmt_cfg_i[3:1] == 3'b110))
      |-> (addr_r_o[CH_W-1:IDX15_W] == '0 && addr_g_o[CH_W-1:IDX15_W] == '0
           && addr_b_o[CH_W-1:IDX15_W] == '0));
endmodule

bind pxfmt_top pxfmt_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fmt_cfg_i    (fmt_cfg_i),
  .wide_i       (wide_i),
  .sog_en_i     (sog_en_i),
  .sync_out_en_i(sync_out_en_i),
  .addr_r_o     (addr_r_o),
  .addr_g_o     (addr_g_o),
  .addr_b_o     (addr_b_o),
  .wide_o       (wide_o),
  .sog_o        (sog_o),
  .sync_o       (sync_o),
  .en_o         (en_o)
);

// File: tb/sim_pxfmt_top.sv
module sim_pxfmt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, mux2_i, wide_i, sog_en_i, sync_out_en_i, sync_i, blank_i;
  logic [3:0]  fmt_cfg_i;
  logic [1:0]  pal_code_i, psel_a_i, psel_b_i;
  logic [23:0] pix_a_i, pix_b_i;
  logic [7:0]  addr_r_o, addr_g_o, addr_b_o;
  logic        wide_o, blank_o, sog_o, sync_o, en_o;

  always #10 clk = ~clk;

  pxfmt_top u0 (.*);

  typedef struct {
    int         cyc;
    string      req;
    logic [7:0] ar, ag, ab;
    logic       en, wd, bl, sg, sy;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [23:0] p, input logic [1:0] ps,
                                 input logic sy, input logic bl, input string req);
    exp_t e;
    logic [7:0] r, g, b;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    e.req = req;
    if (fmt_cfg_i[3:2] == 2'b00)      begin e.ar = r; e.ag = r; e.ab = r; end
    else if (fmt_cfg_i[3:2] == 2'b01) begin e.ar = g; e.ag = g; e.ab = g; end
    else if (fmt_cfg_i[3:2] == 2'b10) begin e.ar = b; e.ag = b; e.ab = b; end
    else if (fmt_cfg_i[1])            begin e.ar = r; e.ag = g; e.ab = b; end
    else if (fmt_cfg_i[0]) begin
      e.ar = {3'b0, r[7:3]}; e.ag = {3'b0, r[2:0], g[6:5]}; e.ab = {3'b0, g[4:0]};
    end else begin
      e.ar = {3'b0, r[7:3]}; e.ag = {3'b0, g[7:3]}; e.ab = {3'b0, b[7:3]};
    end
    e.en = (ps == pal_code_i);
    if (!e.en) begin e.ar = 0; e.ag = 0; e.ab = 0; end
    e.wd = wide_i;
    e.bl = bl;
    e.sg = sy & sog_en_i;
    e.sy = sy & sync_out_en_i;
    return e;
  endfunction

  // one load; in 2:1 mode takes two clocks, in 1:1 one clock (plus idle hold clocks)
  task automatic do_load(input string req, input logic [23:0] pa, input logic [23:0] pb,
                         input logic [1:0] sa, input logic [1:0] sb,
                         input logic sy, input logic bl, input int hold);
    exp_t e;
    @(negedge clk);
    pix_a_i = pa; pix_b_i = pb; psel_a_i = sa; psel_b_i = sb;
    sync_i = sy; blank_i = bl; load_i = 1'b1;
    e = model(pa, sa, sy, bl, req); e.cyc = cyc + 2; q.push_back(e);
    if (mux2_i) begin
      e = model(pb, sb, sy, bl, req); e.cyc = cyc + 3; q.push_back(e);
    end else begin
      for (int k = 1; k <= hold; k++) begin
        e = model(pa, sa, sy, bl, req); e.cyc = cyc + 2 + k; q.push_back(e);
      end
    end
    if (mux2_i) begin
      @(negedge clk);
      load_i = 1'b0;
      pix_a_i = ~pa; pix_b_i = ~pb; sync_i = ~sy; blank_i = ~bl;
    end
    if (hold > 0) begin
      @(negedge clk);
      load_i = 1'b0;
      pix_a_i = ~pa; sync_i = ~sy; blank_i = ~bl; psel_a_i = ~sa;
      repeat (hold - 1) @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    load_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() != 0 && q[0].cyc < cyc) begin
        chk(1'b0, q[0].req, "missed item", 0, q[0].cyc);
        void'(q.pop_front());
      end
      if (q.size() != 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(addr_r_o == e.ar, e.req, "addr_r", addr_r_o, e.ar);
        chk(addr_g_o == e.ag, e.req, "addr_g", addr_g_o, e.ag);
        chk(addr_b_o == e.ab, e.req, "addr_b", addr_b_o, e.ab);
        chk(en_o == e.en, e.req, "en (R8)", en_o, e.en);
        chk(wide_o == e.wd, e.req, "wide (R7)", wide_o, e.wd);
        chk(blank_o == e.bl, e.req, "blank (R10)", blank_o, e.bl);
        chk(sog_o == e.sg, e.req, "sog (R9)", sog_o, e.sg);
        chk(sync_o == e.sy, e.req, "sync (R10)", sync_o, e.sy);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; mux2_i = 1'b0; wide_i = 1'b1;
    sog_en_i = 1'b1; sync_out_en_i = 1'b1; sync_i = 1'b1; blank_i = 1'b1;
    fmt_cfg_i = 4'b1110; pal_code_i = 2'd2; psel_a_i = 2'd2; psel_b_i = 2'd2;
    pix_a_i = 24'hFFFFFF; pix_b_i = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero during reset
    chk({addr_r_o, addr_g_o, addr_b_o} == 24'h0, "R11", "addr in reset",
        {addr_r_o, addr_g_o, addr_b_o}, 0);
    chk({wide_o, blank_o, sog_o, sync_o, en_o} == 5'b0, "R11", "flags in reset",
        {wide_o, blank_o, sog_o, sync_o, en_o}, 0);
    rst_n = 1'b1;
    sync_i = 1'b0; blank_i = 1'b0;

    // R3 direct mode, 1:1 back to back
    do_load("R3", 24'h12A5C3, 0, 2'd2, 0, 1'b0, 1'b0, 0);
    do_load("R3", 24'h7E0F81, 0, 2'd2, 0, 1'b1, 1'b1, 0);
    do_load("R1", 24'hC35A96, 0, 2'd2, 0, 1'b0, 1'b1, 3);
    drain();

    // R2 2:1 ordering
    mux2_i = 1'b1;
    do_load("R2", 24'hA1B2C3, 24'h4D5E6F, 2'd2, 2'd2, 1'b1, 1'b0, 0);
    do_load("R2", 24'h0F1E2D, 24'hF0E1D2, 2'd2, 2'd2, 1'b0, 1'b1, 0);
    drain();

    // R4 indexed formats (low two cfg bits varied to show they are ignored)
    mux2_i = 1'b0;
    fmt_cfg_i = 4'b0010; do_load("R4", 24'h9C3A57, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();
    fmt_cfg_i = 4'b0000; do_load("R4", 24'h5B7E21, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();
    fmt_cfg_i = 4'b0111; do_load("R4", 24'h9C3A57, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();
    fmt_cfg_i = 4'b1001; do_load("R4", 24'h9C3A57, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();

    // R5 and R6 packed formats
    fmt_cfg_i = 4'b1100; do_load("R5", 24'hB7_6A_E9, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();
    fmt_cfg_i = 4'b1101; do_load("R6", 24'hB7_EA_00, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();
    fmt_cfg_i = 4'b1101; do_load("R6", 24'hB7_6A_FF, 0, 2'd2, 0, 1'b0, 1'b0, 0); drain();

    // R8 per-pixel select in 2:1 mode
    mux2_i = 1'b1; fmt_cfg_i = 4'b1110; pal_code_i = 2'd1;
    do_load("R8", 24'h334455, 24'h667788, 2'd1, 2'd3, 1'b0, 1'b0, 0);
    do_load("R8", 24'h112233, 24'hAABBCC, 2'd0, 2'd1, 1'b1, 1'b1, 0);
    drain();

    // R7 width flag and R9/R10 sync gating
    mux2_i = 1'b0; wide_i = 1'b0; sog_en_i = 1'b0; sync_out_en_i = 1'b1;
    do_load("R7", 24'h13579B, 0, 2'd1, 0, 1'b1, 1'b0, 0); drain();
    sog_en_i = 1'b1; sync_out_en_i = 1'b0; wide_i = 1'b1;
    do_load("R9", 24'h2468AC, 0, 2'd1, 0, 1'b1, 1'b1, 0); drain();
    sog_en_i = 1'b0; sync_out_en_i = 1'b1;
    do_load("R10", 24'hFEDCBA, 0, 2'd1, 0, 1'b1, 1'b0, 1); drain();

    finish_run();
  end
endmodule